// File: doc/BRIEF.md
# Delta-Sigma Converter Serial-Port Sequencer

This block is the digital control core of a single-channel delta-sigma converter. It runs a fixed cycle: a timed conversion, a low-power wait, and then a serial transfer. An internal cycle counter stands in for the conversion period. When that period ends, the block captures a 16-bit result from a parallel input into a holding register. The block then waits with the converter powered down until the host pulls chip select low.

During the transfer the held result is shifted out on SDO, MSB first, with one new bit after each SCK falling edge. At the same time a 4-bit configuration word is sampled from SDI on SCK rising edges. The transfer ends either at the sixteenth SCK falling edge or when chip select rises. Either event starts the next conversion immediately, so no command is needed.

The configuration word does two things. It can double the conversion period to select the slow output rate. It can also have the reference powered down after the next conversion. The block drives power-control outputs for the converter and the reference, reports when the reference has had time to settle, and flags the first result after reset as invalid. The chip-select, SCK and SDI pins are asynchronous to the fast system clock, and each passes through a two-flop synchroniser.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset is released the block is converting: conv_on=1, ref_on=1, sdo_en=0, rate_slow=0 and data_invalid=1.
- R2: With rate_slow=0 a conversion keeps conv_on high for exactly CONV_CYCLES clock cycles, and nothing on the serial pins shortens it.
- R3: When a conversion ends, result_i is captured and conv_on drops. The block then waits until chip select (cs_n) is low before it starts a transfer, and never goes from converting straight to transferring.
- R4: During a transfer, bit 15 of the held result is on sdo before the first SCK falling edge, and bit 15-k is on sdo after the k-th falling edge. SCK rising edges do not change sdo.
- R5: The first four SDI bits, sampled on SCK rising edges, are taken in the order enable-high, enable-low, rate, sleep. The rate and sleep bits are stored only when the first bit is 1 and the second is 0. All later SDI bits are ignored, and the stored values change only during a transfer.
- R6: While cs_n is high, sdo_en=0, and SCK and SDI have no effect.
- R7: A transfer ends at the sixteenth SCK falling edge, or earlier when cs_n rises, and a new conversion starts at once (conv_on=1). If cs_n rises before the fourth SDI bit has been sampled, the stored configuration is left unchanged.
- R8: With sleep=0, ref_on stays 1 after a conversion. With sleep=1, ref_on goes to 0 when the next conversion ends, and returns to 1 when cs_n goes low.
- R9: With rate=1, rate_slow=1 and the conversion lasts 2*CONV_CYCLES cycles.
- R10: ref_ready is 0 while the reference is off, and rises REF_WAKE_CYCLES cycles after ref_on rises.
- R11: data_invalid stays 1 until the second conversion after reset has completed, and is 0 after that.
- R12: While cs_n is low and a conversion is running, sdo is driven high as a busy indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial configuration data in |
| result_i | input | DATA_W | Conversion result from the datapath |
| sdo | output | 1 | Serial data out; valid while sdo_en=1 |
| sdo_en | output | 1 | Output enable for the SDO pad (0 = high impedance) |
| conv_on | output | 1 | Converter powered and converting |
| ref_on | output | 1 | Reference powered |
| ref_ready | output | 1 | Reference has had its settling time |
| rate_slow | output | 1 | Slow rate with offset calibration selected |
| data_invalid | output | 1 | Held result is not trustworthy (first after reset) |

## Verification
A wrong conversion count shows up in the length of the conv_on pulse, and it is measured on every conversion. A fault in the transfer bit counter shifts or truncates the word seen on sdo within the same read. It can also leave conv_on low after the sixteenth falling edge. A configuration register written from the wrong bit, or written without the enable pattern, appears one conversion later as a wrong conversion length, a wrong rate_slow, or a wrong ref_on level. The bench checks all of these after every read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_CONVERT = 2'd0,
    ST_WAIT    = 2'd1,
    ST_XFER    = 2'd2
  } seq_state_t;

  localparam int CFG_BITS = 4;
endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_seq_conv_timer.sv
module adc_seq_conv_timer #(
  parameter int CONV_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic done
);
  localparam int LIM_W = $clog2(2*CONV_CYCLES + 1);

  logic [LIM_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = slow ? LIM_W'(2*CONV_CYCLES) : LIM_W'(CONV_CYCLES);
  assign done = run && (cnt_q == lim - 1'b1);

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_ref_timer.sv
module adc_seq_ref_timer #(
  parameter int WAKE_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_on,
  output logic ready
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_CYCLES);

  logic [WAKE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = !ref_on || (cnt_q != WAKE_LAST);

  always_comb begin
    cnt_d = ref_on ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == WAKE_LAST);
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int CONV_CYCLES     = 2000,
  parameter int REF_WAKE_CYCLES = 1500,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo,
  output logic              sdo_en,
  output logic              conv_on,
  output logic              ref_on,
  output logic              ref_ready,
  output logic              rate_slow,
  output logic              data_invalid
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int CFG_W = $clog2(CFG_BITS + 1);
  localparam logic [BIT_W-1:0] FALL_LAST = BIT_W'(DATA_W - 1);
  localparam logic [CFG_W-1:0] CFG_LAST  = CFG_W'(CFG_BITS - 1);
  localparam logic [CFG_W-1:0] CFG_DONE  = CFG_W'(CFG_BITS);

  logic rst_s;
  logic cs_s, sck_s, sdi_s, sck_d;
  logic sck_rise, sck_fall;
  logic conv_done;

  seq_state_t              state_q, state_d;
  logic [BIT_W-1:0]        fall_q, fall_d;
  logic [CFG_W-1:0]        rise_q, rise_d;
  logic [CFG_BITS-2:0]     cfg_sh_q, cfg_sh_d;
  logic                    spd_q, spd_d, slp_q, slp_d, cfg_en;
  logic [DATA_W-1:0]       hold_q, shifted;
  logic                    hold_en;
  logic                    ref_on_q, ref_on_d;
  logic                    seen_q, seen_d, inval_q, inval_d;

  adc_seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_s));

  adc_seq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_s),
    .async_i({cs_n, sck, sdi}),
    .sync_o({cs_s, sck_s, sdi_s})
  );

  adc_seq_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst_n(rst_s), .run(state_q == ST_CONVERT),
    .slow(spd_q), .done(conv_done)
  );

  adc_seq_ref_timer #(.WAKE_CYCLES(REF_WAKE_CYCLES)) u_ref (
    .clk(clk), .rst_n(rst_s), .ref_on(ref_on_q), .ready(ref_ready)
  );

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    fall_d   = fall_q;
    rise_d   = rise_q;
    cfg_sh_d = cfg_sh_q;
    spd_d    = spd_q;
    slp_d    = slp_q;
    cfg_en   = 1'b0;
    hold_en  = 1'b0;
    ref_on_d = ref_on_q;
    seen_d   = seen_q;
    inval_d  = inval_q;
    unique case (state_q)
      ST_CONVERT: begin
        if (conv_done) begin
          state_d = ST_WAIT;
          hold_en = 1'b1;
          seen_d  = 1'b1;
          if (seen_q) inval_d  = 1'b0;
          if (slp_q)  ref_on_d = 1'b0;
        end
      end
      ST_WAIT: begin
        if (!cs_s) begin
          state_d  = ST_XFER;
          ref_on_d = 1'b1;
          fall_d   = '0;
          rise_d   = '0;
        end
      end
      ST_XFER: begin
        if (cs_s) begin
          state_d = ST_CONVERT;
        end else begin
          if (sck_rise && rise_q != CFG_DONE) begin
            rise_d   = rise_q + 1'b1;
            cfg_sh_d = {cfg_sh_q[CFG_BITS-3:0], sdi_s};
            if (rise_q == CFG_LAST && cfg_sh_q[2] && !cfg_sh_q[1]) begin
              cfg_en = 1'b1;
              spd_d  = cfg_sh_q[0];
              slp_d  = sdi_s;
            end
          end
          if (sck_fall) begin
            if (fall_q == FALL_LAST) state_d = ST_CONVERT;
            else                     fall_d  = fall_q + 1'b1;
          end
        end
      end
      default: state_d = ST_CONVERT;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q  <= ST_CONVERT;
      sck_d    <= 1'b0;
      fall_q   <= '0;
      rise_q   <= '0;
      cfg_sh_q <= '0;
      ref_on_q <= 1'b1;
      seen_q   <= 1'b0;
      inval_q  <= 1'b1;
    end else begin
      state_q  <= state_d;
      sck_d    <= sck_s;
      fall_q   <= fall_d;
      rise_q   <= rise_d;
      cfg_sh_q <= cfg_sh_d;
      ref_on_q <= ref_on_d;
      seen_q   <= seen_d;
      inval_q  <= inval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      spd_q <= 1'b0;
      slp_q <= 1'b0;
    end else if (cfg_en) begin
      spd_q <= spd_d;
      slp_q <= slp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       hold_q <= '0;
    else if (hold_en) hold_q <= result_i;
  end

  assign shifted      = hold_q << fall_q;
  assign sdo          = (state_q == ST_XFER) ? shifted[DATA_W-1] : (state_q == ST_CONVERT);
  assign sdo_en       = ~cs_s;
  assign conv_on      = (state_q == ST_CONVERT);
  assign ref_on       = ref_on_q;
  assign rate_slow    = spd_q;
  assign data_invalid = inval_q;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_s,
  input seq_state_t        state_q,
  input logic              conv_done,
  input logic              cs_s,
  input logic [DATA_W-1:0] result_i,
  input logic [DATA_W-1:0] hold_q,
  input logic              spd_q,
  input logic              slp_q,
  input logic              ref_on_q
);
  AST_NO_CONV_TO_XFER: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_CONVERT) |=> (state_q != ST_XFER)); // R3

  AST_CONV_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_CONVERT && !conv_done) |=> (state_q == ST_CONVERT)); // R2

  AST_RESULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_CONVERT && conv_done) |=> (hold_q == $past(result_i))); // R3

  AST_CS_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_WAIT && cs_s) |=> (state_q == ST_WAIT && $stable(hold_q))); // R6

  AST_CFG_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q != ST_XFER) |=> $stable({spd_q, slp_q})); // R5

  AST_REF_OFF_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q != ST_WAIT) |-> ref_on_q); // R8
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .state_q(state_q), .conv_done(conv_done),
  .cs_s(cs_s), .result_i(result_i), .hold_q(hold_q), .spd_q(spd_q),
  .slp_q(slp_q), .ref_on_q(ref_on_q)
);

// File: tb/adc_serial_seq_bench.sv
module adc_serial_seq_bench;
  localparam int CONV = 40;
  localparam int WAKE = 20;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi;
  logic [15:0] result_i;
  logic sdo, sdo_en, conv_on, ref_on, ref_ready, rate_slow, data_invalid;

  int tests = 0, fails = 0;
  int run_len = 0, last_len = 0;
  logic m_spd = 1'b0, m_slp = 1'b0;
  logic [15:0] latched;

  always #4 clk = ~clk;

  adc_serial_seq #(.DATA_W(16), .CONV_CYCLES(CONV), .REF_WAKE_CYCLES(WAKE)) u_adc_serial_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .result_i(result_i),
    .sdo(sdo), .sdo_en(sdo_en), .conv_on(conv_on), .ref_on(ref_on),
    .ref_ready(ref_ready), .rate_slow(rate_slow), .data_invalid(data_invalid)
  );

  // conversion length monitor
  always @(negedge clk) begin
    if (conv_on === 1'b1) run_len <= run_len + 1;
    else if (run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic spd);
    return spd ? 2*CONV : CONV;
  endfunction

  task automatic wait_idle();
    while (conv_on !== 1'b0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // one transfer: npulse SCK pulses, then CS rises
  task automatic do_read(input logic [3:0] word, input int npulse, input logic [15:0] next_res);
    logic [15:0] got = '0, mask = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    result_i = next_res;
    for (int i = 0; i < npulse; i++) begin
      sdi = (i < 4) ? word[3-i] : 1'($urandom);
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
      got[15-i]  = sdo;
      mask[15-i] = 1'b1;
      sck = 1'b0;
      repeat (8) @(negedge clk);
    end
    check((got & mask) === (latched & mask), "R4 sdo word", got & mask, latched & mask);
    if (npulse == 16) begin
      check(conv_on === 1'b1, "R7 conversion after 16th fall", conv_on, 1);
      check(sdo === 1'b1 && sdo_en === 1'b1, "R12 busy on sdo", {sdo_en, sdo}, 2'b11);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(conv_on === 1'b1, "R7 converting after end of read", conv_on, 1);
    check(sdo_en === 1'b0, "R6 sdo released with cs high", sdo_en, 0);
    if (npulse >= 4 && word[3:2] == 2'b10) begin
      m_spd = word[1];
      m_slp = word[0];
    end
    latched = next_res;
  endtask

  task automatic post_conv_checks();
    wait_idle();
    check(last_len == exp_len(m_spd), "R9 R2 conversion length", last_len, exp_len(m_spd));
    check(rate_slow === m_spd, "R5 rate field", rate_slow, m_spd);
    check(ref_on === !m_slp, "R8 reference after conversion", ref_on, !m_slp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    result_i = 16'hA5C3;
    latched  = 16'hA5C3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(conv_on === 1'b1 && ref_on === 1'b1, "R1 converting with reference", {conv_on, ref_on}, 2'b11);
    check(sdo_en === 1'b0 && rate_slow === 1'b0, "R1 outputs idle", {sdo_en, rate_slow}, 0);
    check(data_invalid === 1'b1, "R1 invalid flag set", data_invalid, 1);

    wait_idle();
    check(conv_on === 1'b0 && ref_on === 1'b1, "R3 nap after conversion", {conv_on, ref_on}, 2'b01);
    check(data_invalid === 1'b1, "R11 first result invalid", data_invalid, 1);
    check(ref_ready === 1'b1, "R10 reference settled after reset", ref_ready, 1);

    // R6: SCK toggles with CS high change nothing
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1; sck = 1'b1; repeat (6) @(negedge clk);
      sck = 1'b0; repeat (6) @(negedge clk);
    end
    check(conv_on === 1'b0 && sdo_en === 1'b0, "R6 idle while cs high", {conv_on, sdo_en}, 0);

    // full read, word without enable
    do_read(4'b0000, 16, 16'h1234);
    post_conv_checks();
    check(data_invalid === 1'b0, "R11 second result valid", data_invalid, 0);

    // program slow rate and sleep
    do_read(4'b1011, 16, 16'h8001);
    check(rate_slow === 1'b1, "R9 slow rate flag", rate_slow, 1);
    post_conv_checks();
    check(ref_ready === 1'b0, "R10 not ready while reference off", ref_ready, 0);

    // wake reference by CS low
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    check(ref_on === 1'b1 && ref_ready === 1'b0, "R8 R10 reference waking", {ref_on, ref_ready}, 2'b10);
    repeat (WAKE + 5) @(negedge clk);
    check(ref_ready === 1'b1, "R10 reference ready after wake time", ref_ready, 1);

    // wrong enable pattern (EN2=1): no change
    do_read(4'b1100, 16, 16'h7FFE);
    post_conv_checks();

    // abort before the 4th SDI bit: no change
    do_read(4'b1000, 2, 16'hC00C);
    post_conv_checks();

    // back to defaults
    do_read(4'b1000, 16, 16'h0F0F);
    post_conv_checks();

    // constrained random traffic
    for (int k = 0; k < 10; k++) begin
      logic [3:0] w;
      int np;
      w = 4'($urandom);
      if ($urandom % 2 == 0) w[3:2] = 2'b10;
      case ($urandom % 5)
        0: np = 2;
        1: np = 3;
        2: np = 4;
        3: np = 7;
        default: np = 16;
      endcase
      do_read(w, np, 16'($urandom));
      post_conv_checks();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule